// File: doc/BRIEF.md
# Disk Device Host Register Interface

This block is the device end of a simple parallel-bus disk controller. A host reaches it through two active-low chip selects, a 3-bit register address, and active-low read and write strobes. It holds the small register file that the host uses to describe a transfer: feature, sector count, sector number, cylinder, and drive/head. It also has a command register, a status register and a device control register. An internal controller sits on the local side. It loads the status byte, supplies the error byte and data words, and requests host interrupts. The block passes each command and each data word to that controller as a one-cycle pulse.

The host strobes are sampled in the core clock domain. A write takes effect on the clock after the write strobe is seen to rise. Read data is driven for as long as the read strobe is low. The tri-state pads sit outside the block. For the data bus (one enable per byte lane), the interrupt line and the active-low 16-bit indication, the block supplies a value and an output enable. A mode input is captured while reset is held, and it selects 16-bit or 8-bit operation until the next reset. A strap tells the device whether it is the primary or the secondary unit on a shared cable.

Top module: `hostif_disk_regs`

## Requirements
- R1: While `rst_n` is low, every register and the interrupt flag clear, so all task-file outputs read 0 and `irq_o` is 0. `mode16` takes the value of `mode16_sel`.
- R2: Register block 0 is selected when `cs0_n`=0 and `cs1_n`=1. A host write there takes effect on the clock edge after `wr_n` is sampled rising. The low byte of `hd_i` is stored in one register chosen by address: 1 feature, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head. Task-file writes are accepted whether or not the device is selected.
- R3: While `rd_n` is low and the device is selected, a block-0 read drives `hd_oe`=01 and places a byte in the low lane. Address 1 gives `loc_error`, addresses 2 to 6 give the stored task-file bytes, and address 7 gives the status byte last loaded by `loc_status_we`. When `rd_n` is high, `hd_oe` is 0.
- R4: Block-0 address 0 is the data register. In 16-bit mode a write passes all 16 bits of `hd_i` to `data_wdata`, with `data_wr_valid` high for one cycle, and a read drives `loc_rdata` on both lanes (`hd_oe`=11). In 8-bit mode the write passes only the low byte (upper bits 0), and the read drives only the low lane.
- R5: `io16_oe` (drive the 16-bit indication low) is high only in 16-bit mode, while block 0 is selected at address 0 and the device is selected. It is never high in 8-bit mode.
- R6: Block 1 (`cs0_n`=1, `cs1_n`=0) exists only in 16-bit mode. Writing address 6 loads the device control byte, in which bit 1 set disables the interrupt. Reading address 6 returns the status byte without clearing the interrupt flag. Reading address 7 returns the drive/head byte. In 8-bit mode every block-1 access is ignored.
- R7: Drive/head bit 4 is compared with `strap_slave`, and the device is selected when they are equal. An unselected device drives no read data and ignores command writes, but it still stores task-file writes.
- R8: A block-0 write to address 7 on a selected device produces `cmd_valid` for exactly one cycle, with `cmd_code` equal to the written byte.
- R9: `loc_irq_set` sets the interrupt flag on the next clock. Two things clear it on the clock after the strobe rises: a selected host read of block-0 address 7, or a selected command write. A set on the same clock as a clear wins.
- R10: `irq_o` shows the interrupt flag. In 16-bit mode, `irq_oe` is high only when the device is selected and device control bit 1 is 0. In 8-bit mode, `irq_oe` is high whenever the device is selected.
- R11: After reset is released, changes on `mode16_sel` have no effect on `mode16`.
- R12: With both chip selects low, or both high, no register is read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Host reset, active low, synchronous |
| mode16_sel | input | 1 | Mode request captured during reset (1 = 16-bit) |
| strap_slave | input | 1 | Unit position strap (1 = secondary) |
| cs0_n | input | 1 | Chip select for register block 0, active low |
| cs1_n | input | 1 | Chip select for register block 1, active low |
| addr | input | 3 | Register address |
| wr_n | input | 1 | Host write strobe, active low |
| rd_n | input | 1 | Host read strobe, active low |
| hd_i | input | 16 | Host data bus, input side |
| hd_o | output | 16 | Host data bus, output value |
| hd_oe | output | 2 | Output enable per byte lane |
| irq_o | output | 1 | Interrupt flag value toward the pad |
| irq_oe | output | 1 | Interrupt pad output enable |
| io16_oe | output | 1 | Drive the active-low 16-bit indication low |
| mode16 | output | 1 | Captured mode (1 = 16-bit) |
| loc_status_we | input | 1 | Local load of the status byte |
| loc_status | input | 8 | Status byte from the local controller |
| loc_error | input | 8 | Error byte from the local controller |
| loc_irq_set | input | 1 | Local interrupt request pulse |
| loc_rdata | input | 16 | Data word for host reads |
| cmd_valid | output | 1 | One-cycle pulse for a new command |
| cmd_code | output | 8 | Command byte |
| data_wr_valid | output | 1 | One-cycle pulse for a host data write |
| data_wdata | output | 16 | Host data word |
| data_rd_done | output | 1 | Pulse at the end of a host data read |
| tf_feature | output | 8 | Feature byte |
| tf_count | output | 8 | Sector count |
| tf_sector | output | 8 | Sector number |
| tf_cyl | output | 16 | Cylinder number |
| tf_head | output | 4 | Head number |

## Verification
Read data, lane enables and the 16-bit indication follow the inputs in the same cycle. The bench therefore samples them 1 ns after it lowers the read strobe, well before the next rising edge. Register contents, `cmd_valid`, `data_wr_valid` and the interrupt flag change on the first clock edge after a strobe is seen high, or after `loc_irq_set` is seen high. The bench raises the strobe at a falling edge and samples those results at the next falling edge, which is half a cycle after the updating edge. Each pulse output is captured in that one-cycle window.

// File: rtl/hostif_pkg.sv
package hostif_pkg;

   // register block 0 addresses
   localparam logic [2:0] RA_DATA    = 3'd0;
   localparam logic [2:0] RA_FEAT    = 3'd1;
   localparam logic [2:0] RA_COUNT   = 3'd2;
   localparam logic [2:0] RA_SECT    = 3'd3;
   localparam logic [2:0] RA_CYL_LO  = 3'd4;
   localparam logic [2:0] RA_CYL_HI  = 3'd5;
   localparam logic [2:0] RA_DRVHD   = 3'd6;
   localparam logic [2:0] RA_CMDSTAT = 3'd7;

   // register block 1 addresses (16-bit mode only)
   localparam logic [2:0] RA_CTL     = 3'd6;
   localparam logic [2:0] RA_DRVADDR = 3'd7;

   typedef struct packed {
      logic blk0;
      logic blk1;
      logic wr_ev;
      logic rd_ev;
      logic rd_act;
   } host_acc_t;

endpackage

// File: rtl/hostif_decode.sv
module hostif_decode (
   input  logic clk,
   input  logic rst_n,
   input  logic mode16,
   input  logic cs0_n,
   input  logic cs1_n,
   input  logic wr_n,
   input  logic rd_n,
   output hostif_pkg::host_acc_t acc
);

   logic wr_q;
   logic rd_q;
   logic any_blk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q <= 1'b1;
         rd_q <= 1'b1;
      end else begin
         wr_q <= wr_n;
         rd_q <= rd_n;
      end
   end

   always_comb begin
      acc.blk0   = !cs0_n && cs1_n;
      acc.blk1   = cs0_n && !cs1_n && mode16;
      any_blk    = acc.blk0 || acc.blk1;
      acc.wr_ev  = wr_n && !wr_q && any_blk;
      acc.rd_ev  = rd_n && !rd_q && any_blk;
      acc.rd_act = !rd_n && any_blk;
   end

endmodule

// File: rtl/hostif_taskfile.sv
module hostif_taskfile #(
   parameter int REG_W   = 8,
   parameter int DATA_W  = 16,
   parameter int DEV_BIT = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mode16,
   input  logic                  strap_slave,
   input  hostif_pkg::host_acc_t acc,
   input  logic [2:0]            addr,
   input  logic [DATA_W-1:0]     hd_i,
   input  logic                  loc_status_we,
   input  logic [REG_W-1:0]      loc_status,
   output logic [REG_W-1:0]      feature,
   output logic [REG_W-1:0]      count,
   output logic [REG_W-1:0]      sector,
   output logic [REG_W-1:0]      cyl_lo,
   output logic [REG_W-1:0]      cyl_hi,
   output logic [REG_W-1:0]      drvhd,
   output logic [REG_W-1:0]      devctl,
   output logic [REG_W-1:0]      status,
   output logic                  selected,
   output logic                  cmd_valid,
   output logic [REG_W-1:0]      cmd_code,
   output logic                  data_wr_valid,
   output logic [DATA_W-1:0]     data_wdata
);
   import hostif_pkg::*;

   logic [DATA_W-1:0] lane_mask;
   logic              wr0;
   logic              wr1;

   generate
      if (DATA_W > REG_W) begin : g_wide
         assign lane_mask = mode16 ? {DATA_W{1'b1}}
                                   : {{(DATA_W-REG_W){1'b0}}, {REG_W{1'b1}}};
      end else begin : g_narrow
         assign lane_mask = {DATA_W{1'b1}};
      end
   endgenerate

   assign selected = (drvhd[DEV_BIT] == strap_slave);
   assign wr0      = acc.wr_ev && acc.blk0;
   assign wr1      = acc.wr_ev && acc.blk1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         feature       <= '0;
         count         <= '0;
         sector        <= '0;
         cyl_lo        <= '0;
         cyl_hi        <= '0;
         drvhd         <= '0;
         devctl        <= '0;
         status        <= '0;
         cmd_valid     <= 1'b0;
         cmd_code      <= '0;
         data_wr_valid <= 1'b0;
         data_wdata    <= '0;
      end else begin
         if (wr0) begin
            case (addr)
               RA_FEAT:   feature <= hd_i[REG_W-1:0];
               RA_COUNT:  count   <= hd_i[REG_W-1:0];
               RA_SECT:   sector  <= hd_i[REG_W-1:0];
               RA_CYL_LO: cyl_lo  <= hd_i[REG_W-1:0];
               RA_CYL_HI: cyl_hi  <= hd_i[REG_W-1:0];
               RA_DRVHD:  drvhd   <= hd_i[REG_W-1:0];
               default: ;
            endcase
         end
         if (wr1 && addr == RA_CTL) devctl <= hd_i[REG_W-1:0];
         if (loc_status_we) status <= loc_status;

         cmd_valid <= wr0 && selected && addr == RA_CMDSTAT;
         if (wr0 && selected && addr == RA_CMDSTAT) cmd_code <= hd_i[REG_W-1:0];

         data_wr_valid <= wr0 && selected && addr == RA_DATA;
         if (wr0 && selected && addr == RA_DATA) data_wdata <= hd_i & lane_mask;
      end
   end

endmodule

// File: rtl/hostif_irq.sv
module hostif_irq #(
   parameter int NIEN_BIT = 1,
   parameter int REG_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode16,
   input  logic             selected,
   input  logic [REG_W-1:0] devctl,
   input  logic             set_req,
   input  logic             clr_req,
   output logic             flag,
   output logic             drive_en
);

   always_ff @(posedge clk) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set_req) flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
   end

   assign drive_en = selected && (!mode16 || !devctl[NIEN_BIT]);

endmodule

// File: rtl/hostif_disk_regs.sv
module hostif_disk_regs #(
   parameter int REG_W    = 8,
   parameter int DATA_W   = 16,
   parameter int HEAD_W   = 4,
   parameter int DEV_BIT  = 4,
   parameter int NIEN_BIT = 1,
   localparam int LANES   = DATA_W / REG_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode16_sel,
   input  logic                strap_slave,
   input  logic                cs0_n,
   input  logic                cs1_n,
   input  logic [2:0]          addr,
   input  logic                wr_n,
   input  logic                rd_n,
   input  logic [DATA_W-1:0]   hd_i,
   output logic [DATA_W-1:0]   hd_o,
   output logic [LANES-1:0]    hd_oe,
   output logic                irq_o,
   output logic                irq_oe,
   output logic                io16_oe,
   output logic                mode16,
   input  logic                loc_status_we,
   input  logic [REG_W-1:0]    loc_status,
   input  logic [REG_W-1:0]    loc_error,
   input  logic                loc_irq_set,
   input  logic [DATA_W-1:0]   loc_rdata,
   output logic                cmd_valid,
   output logic [REG_W-1:0]    cmd_code,
   output logic                data_wr_valid,
   output logic [DATA_W-1:0]   data_wdata,
   output logic                data_rd_done,
   output logic [REG_W-1:0]    tf_feature,
   output logic [REG_W-1:0]    tf_count,
   output logic [REG_W-1:0]    tf_sector,
   output logic [2*REG_W-1:0]  tf_cyl,
   output logic [HEAD_W-1:0]   tf_head
);
   import hostif_pkg::*;

   initial begin
      if (DATA_W % REG_W != 0 || DATA_W < REG_W)
         $error("DATA_W must be a whole multiple of REG_W");
      if (DEV_BIT >= REG_W || NIEN_BIT >= REG_W || HEAD_W > REG_W)
         $error("field position outside the register width");
   end

   host_acc_t        acc;
   logic [REG_W-1:0] cyl_lo, cyl_hi, drvhd, devctl, status;
   logic             selected;
   logic             irq_clr;
   logic             rd_hit;
   logic             rd_data_reg;
   logic [REG_W-1:0] rd_byte;

   always_ff @(posedge clk) begin
      if (!rst_n) mode16 <= mode16_sel;
   end

   hostif_decode i_decode (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode16 (mode16),
      .cs0_n  (cs0_n),
      .cs1_n  (cs1_n),
      .wr_n   (wr_n),
      .rd_n   (rd_n),
      .acc    (acc)
   );

   hostif_taskfile #(
      .REG_W   (REG_W),
      .DATA_W  (DATA_W),
      .DEV_BIT (DEV_BIT)
   ) i_taskfile (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode16        (mode16),
      .strap_slave   (strap_slave),
      .acc           (acc),
      .addr          (addr),
      .hd_i          (hd_i),
      .loc_status_we (loc_status_we),
      .loc_status    (loc_status),
      .feature       (tf_feature),
      .count         (tf_count),
      .sector        (tf_sector),
      .cyl_lo        (cyl_lo),
      .cyl_hi        (cyl_hi),
      .drvhd         (drvhd),
      .devctl        (devctl),
      .status        (status),
      .selected      (selected),
      .cmd_valid     (cmd_valid),
      .cmd_code      (cmd_code),
      .data_wr_valid (data_wr_valid),
      .data_wdata    (data_wdata)
   );

   assign irq_clr = selected && acc.blk0 && addr == RA_CMDSTAT && (acc.rd_ev || acc.wr_ev);

   hostif_irq #(
      .NIEN_BIT (NIEN_BIT),
      .REG_W    (REG_W)
   ) i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode16   (mode16),
      .selected (selected),
      .devctl   (devctl),
      .set_req  (loc_irq_set),
      .clr_req  (irq_clr),
      .flag     (irq_o),
      .drive_en (irq_oe)
   );

   assign tf_cyl       = {cyl_hi, cyl_lo};
   assign tf_head      = drvhd[HEAD_W-1:0];
   assign rd_data_reg  = acc.blk0 && addr == RA_DATA;
   assign io16_oe      = mode16 && selected && rd_data_reg;
   assign data_rd_done = acc.rd_ev && selected && rd_data_reg;

   // read byte selection for the low lane
   always_comb begin
      rd_hit  = 1'b0;
      rd_byte = '0;
      if (acc.blk0) begin
         rd_hit = 1'b1;
         case (addr)
            RA_DATA:   rd_byte = loc_rdata[REG_W-1:0];
            RA_FEAT:   rd_byte = loc_error;
            RA_COUNT:  rd_byte = tf_count;
            RA_SECT:   rd_byte = tf_sector;
            RA_CYL_LO: rd_byte = cyl_lo;
            RA_CYL_HI: rd_byte = cyl_hi;
            RA_DRVHD:  rd_byte = drvhd;
            default:   rd_byte = status;
         endcase
      end else if (acc.blk1) begin
         if (addr == RA_CTL) begin
            rd_hit  = 1'b1;
            rd_byte = status;
         end else if (addr == RA_DRVADDR) begin
            rd_hit  = 1'b1;
            rd_byte = drvhd;
         end
      end
   end

   // per-lane bus drive
   genvar ln;
   generate
      for (ln = 0; ln < LANES; ln++) begin : g_lane
         if (ln == 0) begin : g_low
            assign hd_o[REG_W-1:0] = rd_byte;
            assign hd_oe[0]        = acc.rd_act && selected && rd_hit;
         end else begin : g_high
            assign hd_o[ln*REG_W +: REG_W] = loc_rdata[ln*REG_W +: REG_W];
            assign hd_oe[ln] = acc.rd_act && selected && rd_data_reg && mode16;
         end
      end
   endgenerate

endmodule

// File: rtl/hostif_checker.sv
module hostif_checker #(
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_n,
   input logic             cs0_n,
   input logic             cs1_n,
   input logic [2:0]       addr,
   input logic [LANES-1:0] hd_oe,
   input logic             io16_oe,
   input logic             mode16,
   input logic             cmd_valid,
   input logic             loc_irq_set,
   input logic             irq_o
);

   a_r3_bus_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      (|hd_oe) |-> !rd_n);

   a_r5_io16_decode: assert property (@(posedge clk) disable iff (!rst_n)
      io16_oe |-> (mode16 && !cs0_n && cs1_n && addr == 3'd0));

   a_r8_cmd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   a_r9_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
      loc_irq_set |=> irq_o);

   a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(mode16));

   a_r12_dual_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs0_n && !cs1_n) |-> (hd_oe == '0 && !io16_oe));

endmodule

bind hostif_disk_regs hostif_checker #(.LANES(LANES)) i_hostif_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_n        (rd_n),
   .cs0_n       (cs0_n),
   .cs1_n       (cs1_n),
   .addr        (addr),
   .hd_oe       (hd_oe),
   .io16_oe     (io16_oe),
   .mode16      (mode16),
   .cmd_valid   (cmd_valid),
   .loc_irq_set (loc_irq_set),
   .irq_o       (irq_o)
);

// File: tb/test_hostif_disk_regs.sv
module test_hostif_disk_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode16_sel = 1'b1;
   logic        strap_slave = 1'b0;
   logic        cs0_n = 1'b1, cs1_n = 1'b1;
   logic [2:0]  addr = '0;
   logic        wr_n = 1'b1, rd_n = 1'b1;
   logic [15:0] hd_i = '0;
   logic [15:0] hd_o;
   logic [1:0]  hd_oe;
   logic        irq_o, irq_oe, io16_oe, mode16;
   logic        loc_status_we = 1'b0;
   logic [7:0]  loc_status = '0;
   logic [7:0]  loc_error = 8'hE5;
   logic        loc_irq_set = 1'b0;
   logic [15:0] loc_rdata = 16'hA55A;
   logic        cmd_valid, data_wr_valid, data_rd_done;
   logic [7:0]  cmd_code, tf_feature, tf_count, tf_sector;
   logic [15:0] data_wdata, tf_cyl;
   logic [3:0]  tf_head;

   int checks = 0;
   int failures = 0;
   logic        saw_cmd, saw_dwr;
   logic [7:0]  saw_code;
   logic [15:0] saw_wdata;
   logic [15:0] rd_d;
   logic [1:0]  rd_oe;
   logic        rd_io16;

   always #2.5 clk = ~clk;

   hostif_disk_regs i_hostif_disk_regs (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic c0, input logic c1, input logic [2:0] a,
                             input logic [15:0] d);
      cs0_n = c0; cs1_n = c1; addr = a; hd_i = d; wr_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1;
      @(negedge clk);
      saw_cmd = cmd_valid; saw_code = cmd_code;
      saw_dwr = data_wr_valid; saw_wdata = data_wdata;
      cs0_n = 1'b1; cs1_n = 1'b1;
   endtask

   task automatic host_read(input logic c0, input logic c1, input logic [2:0] a);
      cs0_n = c0; cs1_n = c1; addr = a; rd_n = 1'b0;
      #1;
      rd_d = hd_o; rd_oe = hd_oe; rd_io16 = io16_oe;
      @(negedge clk);
      rd_n = 1'b1;
      @(negedge clk);
      cs0_n = 1'b1; cs1_n = 1'b1;
   endtask

   task automatic irq_pulse();
      loc_irq_set = 1'b1;
      @(negedge clk);
      loc_irq_set = 1'b0;
   endtask

   task automatic do_reset(input logic m16);
      rst_n = 1'b0; mode16_sel = m16;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset(1'b1);
      chk("R1 count", tf_count, 0);
      chk("R1 cyl", tf_cyl, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 mode16", mode16, 1);
   endtask

   task automatic t_taskfile();
      host_write(1'b0, 1'b1, 3'd1, 16'h0011);
      host_write(1'b0, 1'b1, 3'd2, 16'h0022);
      host_write(1'b0, 1'b1, 3'd3, 16'h0033);
      host_write(1'b0, 1'b1, 3'd4, 16'h0044);
      host_write(1'b0, 1'b1, 3'd5, 16'h0055);
      host_write(1'b0, 1'b1, 3'd6, 16'h0003);
      chk("R2 feature", tf_feature, 8'h11);
      chk("R2 count", tf_count, 8'h22);
      chk("R2 sector", tf_sector, 8'h33);
      chk("R2 cyl", tf_cyl, 16'h5544);
      chk("R2 head", tf_head, 4'h3);
   endtask

   task automatic t_readback();
      loc_status = 8'h58; loc_status_we = 1'b1;
      @(negedge clk);
      loc_status_we = 1'b0;
      host_read(1'b0, 1'b1, 3'd2);
      chk("R3 count data", rd_d[7:0], 8'h22);
      chk("R3 count lanes", rd_oe, 2'b01);
      host_read(1'b0, 1'b1, 3'd1);
      chk("R3 error byte", rd_d[7:0], 8'hE5);
      host_read(1'b0, 1'b1, 3'd7);
      chk("R3 status byte", rd_d[7:0], 8'h58);
      chk("R3 idle bus", hd_oe, 2'b00);
   endtask

   task automatic t_data16();
      host_write(1'b0, 1'b1, 3'd0, 16'hBEEF);
      chk("R4 wr valid", saw_dwr, 1);
      chk("R4 wdata", saw_wdata, 16'hBEEF);
      host_read(1'b0, 1'b1, 3'd0);
      chk("R4 rdata", rd_d, 16'hA55A);
      chk("R4 lanes", rd_oe, 2'b11);
      chk("R5 io16 on data", rd_io16, 1);
      host_read(1'b0, 1'b1, 3'd3);
      chk("R5 io16 off reg", rd_io16, 0);
   endtask

   task automatic t_ctl();
      irq_pulse();
      chk("R9 irq set", irq_o, 1);
      chk("R10 irq driven", irq_oe, 1);
      host_write(1'b1, 1'b0, 3'd6, 16'h0002);
      chk("R10 irq disabled", irq_oe, 0);
      host_read(1'b1, 1'b0, 3'd6);
      chk("R6 alt status", rd_d[7:0], 8'h58);
      chk("R9 alt keeps irq", irq_o, 1);
      host_read(1'b1, 1'b0, 3'd7);
      chk("R6 drive addr", rd_d[7:0], 8'h03);
      host_write(1'b1, 1'b0, 3'd6, 16'h0000);
      chk("R10 irq re-enabled", irq_oe, 1);
   endtask

   task automatic t_irq_clear();
      host_read(1'b0, 1'b1, 3'd7);
      chk("R9 status read clears", irq_o, 0);
      irq_pulse();
      host_write(1'b0, 1'b1, 3'd7, 16'h0020);
      chk("R8 cmd valid", saw_cmd, 1);
      chk("R8 cmd code", saw_code, 8'h20);
      chk("R9 cmd clears", irq_o, 0);
      @(negedge clk);
      chk("R8 cmd one cycle", cmd_valid, 0);
      // set and clear on the same edge
      cs0_n = 1'b0; addr = 3'd7; rd_n = 1'b0;
      @(negedge clk);
      rd_n = 1'b1; loc_irq_set = 1'b1;
      @(negedge clk);
      loc_irq_set = 1'b0; cs0_n = 1'b1;
      chk("R9 set wins", irq_o, 1);
   endtask

   task automatic t_devsel();
      host_write(1'b0, 1'b1, 3'd6, 16'h0010);
      chk("R7 unselected irq", irq_oe, 0);
      host_read(1'b0, 1'b1, 3'd2);
      chk("R7 no read drive", rd_oe, 2'b00);
      host_write(1'b0, 1'b1, 3'd7, 16'h0030);
      chk("R7 cmd ignored", saw_cmd, 0);
      host_write(1'b0, 1'b1, 3'd2, 16'h0066);
      chk("R7 taskfile still written", tf_count, 8'h66);
      host_write(1'b0, 1'b1, 3'd6, 16'h0000);
      chk("R7 reselected", irq_oe, 1);
   endtask

   task automatic t_dual_cs();
      host_read(1'b0, 1'b0, 3'd2);
      chk("R12 no read", rd_oe, 2'b00);
      host_write(1'b0, 1'b0, 3'd2, 16'h0077);
      chk("R12 no write", tf_count, 8'h66);
      host_write(1'b1, 1'b1, 3'd2, 16'h0088);
      chk("R12 none selected", tf_count, 8'h66);
   endtask

   task automatic t_mode8();
      do_reset(1'b0);
      mode16_sel = 1'b1;
      @(negedge clk);
      chk("R11 mode held", mode16, 0);
      host_write(1'b0, 1'b1, 3'd0, 16'h1234);
      chk("R4 8-bit wdata", saw_wdata, 16'h0034);
      host_read(1'b0, 1'b1, 3'd0);
      chk("R4 8-bit lanes", rd_oe, 2'b01);
      chk("R5 no io16 8-bit", rd_io16, 0);
      host_write(1'b1, 1'b0, 3'd6, 16'h0002);
      irq_pulse();
      chk("R10 8-bit irq driven", irq_oe, 1);
      chk("R6 ctl write ignored", irq_o, 1);
      host_read(1'b1, 1'b0, 3'd6);
      chk("R6 block1 read ignored", rd_oe, 2'b00);
   endtask

   initial begin
      t_reset();
      t_taskfile();
      t_readback();
      t_data16();
      t_ctl();
      t_irq_clear();
      t_devsel();
      t_dual_cs();
      t_mode8();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule